// File: doc/BRIEF.md
# Single-Entry Victim Writeback Buffer

This block sits between a write-back, direct-mapped second-level cache and main memory. When a cache miss evicts a block that is marked dirty, the cache controller hands that block to the buffer. The refill of the missing block can then go ahead at once, and the old contents do not have to reach memory first. The buffer holds the victim until the controller reports that the new block has been written into the cache. Only then does it offer the victim to memory as a single 256-bit beat with a valid/ready handshake. A clean victim is dropped without being stored.

There is exactly one entry. If a second dirty victim arrives while the entry is occupied, the stall output rises in the same cycle and the victim is refused until the entry has drained. A lookup port lets the controller check every miss address against the buffered victim. On a match, the block is returned from the buffer, so memory, which may still hold stale data, is never read for it. For a miss that does not match, the block raises a fetch request unless the miss is a full-block write. A full-block write is written straight into the cache and needs no memory read. A partial write miss allocates the block and needs a read, like any other miss.

Top module: `victim_wb_buffer`

## Requirements
- R1: A victim offered with `evict_valid`=1 and `evict_dirty`=0 is not stored. The buffer stays empty: no later drain and no lookup hit for that address.
- R2: A victim offered with `evict_valid`=1 and `evict_dirty`=1 while the buffer is empty is captured at that clock edge: its 27-bit block address and 256-bit (32-byte) data. The drain later presents exactly these values on `wb_addr` and `wb_data`.
- R3: `wb_valid` stays 0 until `refill_done` has been seen, either in the capture cycle or in any cycle after it. `wb_valid` rises on the clock edge that samples `refill_done`=1, or that samples the capture if both happen in the same cycle.
- R4: While `wb_valid`=1 and `wb_ready`=0, `wb_valid`, `wb_addr` and `wb_data` hold. After the edge that samples `wb_valid`=1 and `wb_ready`=1, the buffer is empty and `wb_valid` is 0.
- R5: `stall` equals `evict_valid & evict_dirty` while the buffer is occupied, in the same cycle, and is 0 while the buffer is empty. A stalled victim is not captured. This includes the cycle in which the drain handshake completes. The victim is taken on the first cycle it is offered with the buffer empty.
- R6: One cycle after a lookup (`lk_valid`=1) whose address equals the address of the occupying victim, `lk_hit` is 1 and `lk_data` equals the buffered data. This holds in every occupied state, including the cycle in which the drain completes.
- R7: One cycle after a lookup, `lk_fetch` is 1 only if the lookup missed the buffer and `lk_full_write` was 0. A hit, a full-block write miss or `lk_valid`=0 gives `lk_fetch`=0, and `lk_valid`=0 also gives `lk_hit`=0.
- R8: After synchronous reset, the buffer is empty, and `wb_valid`, `lk_hit`, `lk_fetch` and `stall` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evict_valid | input | 1 | A victim block is offered this cycle |
| evict_dirty | input | 1 | The offered victim is dirty |
| evict_addr | input | 27 | Block address of the victim |
| evict_data | input | 256 | Victim block contents |
| refill_done | input | 1 | The new block has been written into the cache |
| stall | output | 1 | Dirty victim refused because the entry is occupied |
| wb_valid | output | 1 | Writeback beat offered to memory |
| wb_ready | input | 1 | Memory accepts the writeback beat |
| wb_addr | output | 27 | Writeback block address |
| wb_data | output | 256 | Writeback block contents |
| lk_valid | input | 1 | A miss address is presented for lookup |
| lk_addr | input | 27 | Miss block address |
| lk_full_write | input | 1 | The miss is a full-block write (no memory read needed) |
| lk_hit | output | 1 | Previous lookup matched the buffered victim |
| lk_data | output | 256 | Buffered block for a hit |
| lk_fetch | output | 1 | Previous lookup needs a memory read |

## Verification
Two functions can fall in the same cycle: the drain handshake that empties the entry and a lookup that matches the departing victim. A new dirty victim can also be offered in that same cycle. The bench holds `wb_ready` low while the entry drains, then raises it together with a lookup of the victim's address and a second dirty victim. It expects a hit that returns the old data on the next cycle, `stall` high during the handshake cycle, and capture of the new victim one cycle later. A lookup table run while the entry waits for its refill covers the hit, fetch and full-block-write cases, and a capture with `refill_done` in the same cycle covers the shortest path to a drain.

// File: rtl/vwb_pkg.sv
package vwb_pkg;

  typedef enum logic [1:0] {
    VB_EMPTY = 2'd0,
    VB_WAIT  = 2'd1,
    VB_DRAIN = 2'd2
  } vb_state_e;

endpackage

// File: rtl/vwb_entry.sv
module vwb_entry #(
  parameter int ADDR_W  = 27,
  parameter int BLOCK_W = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [ADDR_W-1:0]  in_addr,
  input  logic [BLOCK_W-1:0] in_data,
  output logic [ADDR_W-1:0]  ent_addr,
  output logic [BLOCK_W-1:0] ent_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_addr <= '0;
      ent_data <= '0;
    end else if (load) begin
      ent_addr <= in_addr;
      ent_data <= in_data;
    end
  end

  AST_ENTRY_HELD: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(ent_addr) && $stable(ent_data))); // R2

endmodule

// File: rtl/vwb_ctrl.sv
module vwb_ctrl
  import vwb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic evict_valid,
  input  logic evict_dirty,
  input  logic refill_done,
  input  logic wb_ready,
  output logic capture,
  output logic stall,
  output logic occupied,
  output logic wb_valid
);

  vb_state_e st_q, st_d;
  logic      dirty_offer;

  assign dirty_offer = evict_valid & evict_dirty;
  assign occupied    = (st_q != VB_EMPTY);
  assign capture     = dirty_offer & ~occupied;
  assign stall       = dirty_offer & occupied;
  assign wb_valid    = (st_q == VB_DRAIN);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      VB_EMPTY: if (capture)     st_d = refill_done ? VB_DRAIN : VB_WAIT;
      VB_WAIT:  if (refill_done) st_d = VB_DRAIN;
      VB_DRAIN: if (wb_ready)    st_d = VB_EMPTY;
      default:                   st_d = VB_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= VB_EMPTY;
    else     st_q <= st_d;
  end

  AST_CLEAN_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (!occupied && evict_valid && !evict_dirty) |=> !occupied); // R1

  AST_DRAIN_AFTER_REFILL: assert property (@(posedge clk) disable iff (rst)
    (st_q == VB_WAIT && !refill_done) |=> !wb_valid); // R3

  AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_ready) |=> wb_valid); // R4

  AST_DRAIN_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && wb_ready) |=> !occupied); // R4

endmodule

// File: rtl/vwb_lookup.sv
module vwb_lookup #(
  parameter int ADDR_W  = 27,
  parameter int BLOCK_W = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_valid,
  input  logic [ADDR_W-1:0]  lk_addr,
  input  logic               lk_full_write,
  input  logic               occupied,
  input  logic [ADDR_W-1:0]  ent_addr,
  input  logic [BLOCK_W-1:0] ent_data,
  output logic               hit_q,
  output logic [BLOCK_W-1:0] data_q,
  output logic               fetch_q
);

  logic hit_d;
  logic fetch_d;

  assign hit_d   = lk_valid & occupied & (lk_addr == ent_addr);
  assign fetch_d = lk_valid & ~hit_d & ~lk_full_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q   <= 1'b0;
      fetch_q <= 1'b0;
    end else begin
      hit_q   <= hit_d;
      fetch_q <= fetch_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        data_q <= '0;
    else if (hit_d) data_q <= ent_data;
  end

  AST_HIT_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> $past(occupied)); // R6

  AST_FETCH_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    fetch_q |-> (!hit_q && !$past(lk_full_write))); // R7

endmodule

// File: rtl/victim_wb_buffer.sv
module victim_wb_buffer #(
  parameter int ADDR_W      = 27,
  parameter int BLOCK_BYTES = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     evict_valid,
  input  logic                     evict_dirty,
  input  logic [ADDR_W-1:0]        evict_addr,
  input  logic [BLOCK_BYTES*8-1:0] evict_data,
  input  logic                     refill_done,
  output logic                     stall,
  output logic                     wb_valid,
  input  logic                     wb_ready,
  output logic [ADDR_W-1:0]        wb_addr,
  output logic [BLOCK_BYTES*8-1:0] wb_data,
  input  logic                     lk_valid,
  input  logic [ADDR_W-1:0]        lk_addr,
  input  logic                     lk_full_write,
  output logic                     lk_hit,
  output logic [BLOCK_BYTES*8-1:0] lk_data,
  output logic                     lk_fetch
);

  localparam int BLOCK_W = BLOCK_BYTES * 8;

  logic capture;
  logic occupied;

  vwb_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .evict_valid (evict_valid),
    .evict_dirty (evict_dirty),
    .refill_done (refill_done),
    .wb_ready    (wb_ready),
    .capture     (capture),
    .stall       (stall),
    .occupied    (occupied),
    .wb_valid    (wb_valid)
  );

  vwb_entry #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) u_entry (
    .clk      (clk),
    .rst      (rst),
    .load     (capture),
    .in_addr  (evict_addr),
    .in_data  (evict_data),
    .ent_addr (wb_addr),
    .ent_data (wb_data)
  );

  vwb_lookup #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) u_lookup (
    .clk           (clk),
    .rst           (rst),
    .lk_valid      (lk_valid),
    .lk_addr       (lk_addr),
    .lk_full_write (lk_full_write),
    .occupied      (occupied),
    .ent_addr      (wb_addr),
    .ent_data      (wb_data),
    .hit_q         (lk_hit),
    .data_q        (lk_data),
    .fetch_q       (lk_fetch)
  );

  AST_WB_STABLE: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_ready) |=> ($stable(wb_addr) && $stable(wb_data))); // R4

  AST_STALL_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(wb_addr) && $stable(wb_data))); // R5

  AST_CAPTURE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (evict_valid && evict_dirty && !stall) |=> (wb_addr == $past(evict_addr))); // R2

endmodule

// File: tb/tb_victim_wb_buffer.sv
module tb_victim_wb_buffer;

  localparam int AW = 27;
  localparam int BW = 256;

  localparam logic [AW-1:0] A_CLEAN = 27'h1111111;
  localparam logic [AW-1:0] A1      = 27'h0123456;
  localparam logic [AW-1:0] A2      = 27'h2ABCDEF;
  localparam logic [AW-1:0] A3      = 27'h0000040;

  // {lk_valid, lk_full_write, lk_addr, expected hit, expected fetch}
  localparam int TAB_N = 6;
  localparam logic [30:0] LK_TAB [TAB_N] = '{
    {1'b1, 1'b0, A1,             1'b1, 1'b0},
    {1'b1, 1'b1, A1,             1'b1, 1'b0},
    {1'b1, 1'b0, A1 ^ 27'h1,     1'b0, 1'b1},
    {1'b1, 1'b1, A1 ^ 27'h1,     1'b0, 1'b0},
    {1'b0, 1'b0, A1,             1'b0, 1'b0},
    {1'b1, 1'b0, 27'h0,          1'b0, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          evict_valid, evict_dirty, refill_done, wb_ready;
  logic [AW-1:0] evict_addr, lk_addr;
  logic [BW-1:0] evict_data;
  logic          stall, wb_valid, lk_valid, lk_full_write, lk_hit, lk_fetch;
  logic [AW-1:0] wb_addr;
  logic [BW-1:0] wb_data, lk_data;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #5 clk = ~clk;

  victim_wb_buffer dut (
    .clk(clk), .rst(rst),
    .evict_valid(evict_valid), .evict_dirty(evict_dirty),
    .evict_addr(evict_addr), .evict_data(evict_data),
    .refill_done(refill_done), .stall(stall),
    .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wb_addr(wb_addr), .wb_data(wb_data),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_full_write(lk_full_write),
    .lk_hit(lk_hit), .lk_data(lk_data), .lk_fetch(lk_fetch)
  );

  function automatic logic [BW-1:0] pat(input logic [31:0] seed);
    return {8{32'hC0DE0000 ^ seed}} ^ {seed, 224'h0};
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic idle_inputs;
    evict_valid = 0; evict_dirty = 0; evict_addr = '0; evict_data = '0;
    refill_done = 0; wb_ready = 0; lk_valid = 0; lk_addr = '0; lk_full_write = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst = 1;
    tick(); tick();
    rst = 0;
    #1;
    // R8 reset state
    chk(wb_valid == 0, "R8 wb_valid", BW'(wb_valid), 0);
    chk(lk_hit == 0,   "R8 lk_hit",   BW'(lk_hit), 0);
    chk(lk_fetch == 0, "R8 lk_fetch", BW'(lk_fetch), 0);
    chk(stall == 0,    "R8 stall",    BW'(stall), 0);

    // R1 clean victim dropped
    evict_valid = 1; evict_dirty = 0; evict_addr = A_CLEAN; evict_data = pat(32'h99);
    #1 chk(stall == 0, "R1 no stall on clean", BW'(stall), 0);
    tick();
    idle_inputs();
    refill_done = 1;
    tick();
    refill_done = 0;
    lk_valid = 1; lk_addr = A_CLEAN;
    tick();
    lk_valid = 0;
    chk(wb_valid == 0, "R1 no drain of clean", BW'(wb_valid), 0);
    chk(lk_hit == 0,   "R1 no hit on clean",   BW'(lk_hit), 0);
    chk(lk_fetch == 1, "R7 fetch after clean", BW'(lk_fetch), 1);

    // R2 capture dirty victim, R3 drain deferred
    evict_valid = 1; evict_dirty = 1; evict_addr = A1; evict_data = pat(32'h1);
    #1 chk(stall == 0, "R5 no stall when empty", BW'(stall), 0);
    tick();
    idle_inputs();
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(wb_valid == 0, "R3 no drain before refill", BW'(wb_valid), 0);
    end

    // table of lookups while the victim waits (R6, R7)
    for (int i = 0; i < TAB_N; i++) begin
      lk_valid      = LK_TAB[i][30];
      lk_full_write = LK_TAB[i][29];
      lk_addr       = LK_TAB[i][28:2];
      tick();
      chk(lk_hit == LK_TAB[i][1],   $sformatf("R6 hit row %0d", i), BW'(lk_hit), BW'(LK_TAB[i][1]));
      chk(lk_fetch == LK_TAB[i][0], $sformatf("R7 fetch row %0d", i), BW'(lk_fetch), BW'(LK_TAB[i][0]));
      if (LK_TAB[i][1])
        chk(lk_data == pat(32'h1), $sformatf("R6 data row %0d", i), lk_data, pat(32'h1));
    end
    idle_inputs();

    // R3 refill completes -> drain offered on next edge
    refill_done = 1;
    tick();
    refill_done = 0;
    chk(wb_valid == 1,     "R3 drain after refill", BW'(wb_valid), 1);
    chk(wb_addr == A1,     "R2 drain addr", BW'(wb_addr), BW'(A1));
    chk(wb_data == pat(1), "R2 drain data", wb_data, pat(1));

    // R4 hold under backpressure, R5 stall on second dirty victim
    evict_valid = 1; evict_dirty = 1; evict_addr = A2; evict_data = pat(32'h2);
    #1 chk(stall == 1, "R5 stall while full", BW'(stall), 1);
    tick();
    chk(wb_valid == 1 && wb_addr == A1, "R4 held addr", BW'(wb_addr), BW'(A1));
    chk(wb_data == pat(1), "R4 held data / R5 not loaded", wb_data, pat(1));

    // same cycle: handshake + lookup hit on the departing victim + offered victim
    wb_ready = 1; lk_valid = 1; lk_addr = A1; lk_full_write = 0;
    #1 chk(stall == 1, "R5 stall in handshake cycle", BW'(stall), 1);
    tick();
    wb_ready = 0; lk_valid = 0;
    chk(wb_valid == 0, "R4 empty after handshake", BW'(wb_valid), 0);
    chk(lk_hit == 1,   "R6 hit in drain cycle", BW'(lk_hit), 1);
    chk(lk_data == pat(1), "R6 data in drain cycle", lk_data, pat(1));
    chk(lk_fetch == 0, "R7 no fetch on hit", BW'(lk_fetch), 0);
    chk(stall == 0,    "R5 stall drops when empty", BW'(stall), 0);
    tick();  // second victim captured at this edge
    evict_valid = 0;
    lk_valid = 1; lk_addr = A2;
    tick();
    lk_valid = 0;
    chk(lk_hit == 1 && lk_data == pat(2), "R2 second victim held", lk_data, pat(2));
    chk(wb_valid == 0, "R3 second victim waits", BW'(wb_valid), 0);
    refill_done = 1;
    tick();
    refill_done = 0;
    wb_ready = 1;
    chk(wb_valid == 1 && wb_addr == A2, "R2 second drain addr", BW'(wb_addr), BW'(A2));
    tick();
    wb_ready = 0;
    chk(wb_valid == 0, "R4 second drain done", BW'(wb_valid), 0);

    // R3 capture and refill in the same cycle
    evict_valid = 1; evict_dirty = 1; evict_addr = A3; evict_data = pat(32'h3);
    refill_done = 1;
    tick();
    idle_inputs();
    chk(wb_valid == 1,     "R3 same-cycle refill drain", BW'(wb_valid), 1);
    chk(wb_data == pat(3), "R2 third drain data", wb_data, pat(3));
    wb_ready = 1;
    tick();
    wb_ready = 0;
    chk(wb_valid == 0, "R4 third drain done", BW'(wb_valid), 0);

    // R8 reset while occupied
    evict_valid = 1; evict_dirty = 1; evict_addr = A1; evict_data = pat(32'h4);
    tick();
    idle_inputs();
    rst = 1;
    tick();
    rst = 0;
    #1;
    chk(wb_valid == 0 && stall == 0, "R8 reset clears entry", BW'(wb_valid), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule